// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the load/store stage of a 32-bit pipeline and a memory that is one word wide and addressed in bytes, so word n lives at byte address 4n. It has two independent streaming channels. The store channel takes an access size, a base register value, a signed 16-bit offset and the register data. It returns the word address, one write enable per byte lane and the write word with the data already placed in the right lanes. The load channel takes the same kind of request together with the word read back from memory. It returns the word address and the 32-bit load result: the addressed byte or halfword, sign- or zero-extended, or the whole word.

A single pin chooses how bytes are numbered inside a word. In little-endian mode byte offset 0 is the least significant byte. In big-endian mode byte offset 0 is the most significant byte. The word address is the same in both modes. Every result also carries a flag for a halfword or word access that is not aligned. In that case the lanes and the data are not guaranteed.

Each channel has a valid/ready input side and a valid/ready output side, with one register stage between them. A beat transfers on a rising clock edge when valid and ready are both high. An input is accepted when the output register is empty or is being drained in that same cycle, so `*_in_ready = !*_out_valid || *_out_ready`. While an output is valid but not accepted, its payload stays unchanged. The two channels never stall each other. `big_end_i` is sampled when a request is accepted.

Top module: `lsalign_unit`

## Requirements
- R1: The effective address is the base plus the 16-bit offset sign-extended to 32 bits, modulo 2^32, so negative offsets work. `st_addr` and `ld_addr` present this address with bits [1:0] cleared, and bits [1:0] form the byte offset.
- R2: A byte store (size code 0) sets exactly one enable bit. The bit is the byte offset in little-endian mode and 3 minus the byte offset in big-endian mode. The data byte appears in all four lanes of `st_wword`.
- R3: A halfword store (size code 1) uses address bit 1 to choose a lane pair. In little-endian mode bit1=0 gives enables 0011 and bit1=1 gives 1100; big-endian mode swaps these. The 16-bit data appears in both halves of `st_wword`.
- R4: A word store (size code 2 or 3) sets all four enables and passes the store data through unchanged, whatever the value of address bits [1:0].
- R5: A byte load takes the lane chosen as in R2 from `ld_rword`. It sign-extends when `ld_signed`=1 and zero-extends otherwise. For example, reading byte address 1 of the word 0x23456789 with a signed load gives 0x00000045 in big-endian mode and 0x00000067 in little-endian mode.
- R6: A halfword load takes the lane pair chosen as in R3 and sign-extends or zero-extends it to 32 bits.
- R7: A word load returns `ld_rword` unchanged, whatever the values of `ld_signed` and address bits [1:0].
- R8: The misaligned flag is 1 for a halfword access with address bit 0 set and for a word access with bits [1:0] not zero. It is never 1 for a byte access.
- R9: After reset, both outputs are not valid. Each channel has one cycle of latency. `*_in_ready` equals `!*_out_valid || *_out_ready`. A result that is stalled stays valid and keeps its value.
- R10: The store and load channels are independent. Both can accept a request in the same cycle, and back-pressure on one channel does not stall the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_end_i | input | 1 | 1 = big-endian byte numbering, 0 = little-endian |
| st_in_valid | input | 1 | Store request valid |
| st_in_ready | output | 1 | Store request accepted |
| st_size | input | 2 | Store size code: 0 byte, 1 halfword, 2/3 word |
| st_base | input | 32 | Store base register value |
| st_offs | input | 16 | Store signed offset |
| st_data | input | 32 | Store register data |
| st_out_valid | output | 1 | Store result valid |
| st_out_ready | input | 1 | Store result accepted downstream |
| st_addr | output | 32 | Store word address (bits [1:0] zero) |
| st_be | output | 4 | Per-lane write enables |
| st_wword | output | 32 | Lane-placed write word |
| st_misal | output | 1 | Store misaligned flag |
| ld_in_valid | input | 1 | Load request valid |
| ld_in_ready | output | 1 | Load request accepted |
| ld_size | input | 2 | Load size code: 0 byte, 1 halfword, 2/3 word |
| ld_signed | input | 1 | 1 = sign-extend sub-word loads |
| ld_base | input | 32 | Load base register value |
| ld_offs | input | 16 | Load signed offset |
| ld_rword | input | 32 | Word returned by memory |
| ld_out_valid | output | 1 | Load result valid |
| ld_out_ready | input | 1 | Load result accepted downstream |
| ld_addr | output | 32 | Load word address (bits [1:0] zero) |
| ld_result | output | 32 | Extended load result |
| ld_misal | output | 1 | Load misaligned flag |

## Verification
Store lane formatting and load lane extraction can both accept a request in the same cycle, because they share only the endianness pin. The bench drives both channels from parallel threads, sometimes in exactly the same cycle and in long random runs with random downstream ready on each side. Each result is compared against its own channel's expected queue. In a directed case the load output is held stalled while stores keep flowing. The checks are that the load side reports not-ready, that every queued store drains, and that the stalled load result still matches its expected value when it is finally accepted.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_sz_e;
endpackage

// File: rtl/lsa_ea_gen.sv
module lsa_ea_gen
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16,
  parameter int LB     = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFFS_W-1:0] offs,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LB-1:0]     lane_off,
  output logic              misal
);
  logic [ADDR_W-1:0] offs_sx;
  logic [ADDR_W-1:0] ea;

  // R1: two's complement offset widened before the add
  assign offs_sx   = {{(ADDR_W-OFFS_W){offs[OFFS_W-1]}}, offs};
  assign ea        = base + offs_sx;
  assign word_addr = {ea[ADDR_W-1:LB], {LB{1'b0}}};
  assign lane_off  = ea[LB-1:0];

  // R8: natural alignment per size
  always_comb begin
    case (size)
      ACC_BYTE: misal = 1'b0;
      ACC_HALF: misal = ea[0];
      default:  misal = |ea[LB-1:0];
    endcase
  end
endmodule

// File: rtl/lsa_store_fmt.sv
module lsa_store_fmt
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NL    = DATA_W / 8,
  localparam int LB    = $clog2(NL),
  localparam int HB    = LB - 1
) (
  input  logic [1:0]        size,
  input  logic              big_end,
  input  logic [LB-1:0]     lane_off,
  input  logic [DATA_W-1:0] wdata,
  output logic [NL-1:0]     be,
  output logic [DATA_W-1:0] wword
);
  logic [LB-1:0] byte_lane;
  logic [HB-1:0] hidx;
  logic [HB-1:0] pair;

  assign byte_lane = big_end ? (LB'(NL-1) - lane_off) : lane_off;
  assign hidx      = lane_off[LB-1:1];
  assign pair      = big_end ? (HB'(NL/2-1) - hidx) : hidx;

  // One enable per lane: byte hits one lane, halfword a lane pair, word all
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign be[g] = ((size == ACC_BYTE) && (byte_lane == LB'(g))) ||
                   ((size == ACC_HALF) && (pair == HB'(g/2))) ||
                   ((size != ACC_BYTE) && (size != ACC_HALF));
  end

  // Replicate sub-word data so every candidate lane carries it
  always_comb begin
    case (size)
      ACC_BYTE: wword = {NL{wdata[7:0]}};
      ACC_HALF: wword = {(NL/2){wdata[15:0]}};
      default:  wword = wdata;
    endcase
  end
endmodule

// File: rtl/lsa_load_ext.sv
module lsa_load_ext
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NL    = DATA_W / 8,
  localparam int LB    = $clog2(NL),
  localparam int HB    = LB - 1
) (
  input  logic [1:0]        size,
  input  logic              sgn,
  input  logic              big_end,
  input  logic [LB-1:0]     lane_off,
  input  logic [DATA_W-1:0] rword,
  output logic [DATA_W-1:0] result
);
  logic [LB-1:0] byte_lane;
  logic [HB-1:0] hidx;
  logic [HB-1:0] pair;
  logic [7:0]    bsel;
  logic [15:0]   hsel;

  assign byte_lane = big_end ? (LB'(NL-1) - lane_off) : lane_off;
  assign hidx      = lane_off[LB-1:1];
  assign pair      = big_end ? (HB'(NL/2-1) - hidx) : hidx;
  assign bsel      = rword[{byte_lane, 3'b000} +: 8];
  assign hsel      = rword[{pair, 4'b0000} +: 16];

  always_comb begin
    case (size)
      ACC_BYTE: result = {{(DATA_W-8){sgn & bsel[7]}}, bsel};
      ACC_HALF: result = {{(DATA_W-16){sgn & hsel[15]}}, hsel};
      default:  result = rword;
    endcase
  end
endmodule

// File: rtl/lsa_pipe_reg.sv
module lsa_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  // R9: stalled result keeps its value
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: an accepted beat appears one cycle later
  a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && (out_data == $past(in_data))));
endmodule

// File: rtl/lsalign_unit.sv
module lsalign_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16,
  parameter int DATA_W = 32,
  localparam int NL    = DATA_W / 8,
  localparam int LB    = $clog2(NL),
  localparam int ST_W  = ADDR_W + NL + DATA_W + 1,
  localparam int LD_W  = ADDR_W + DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_end_i,
  input  logic              st_in_valid,
  output logic              st_in_ready,
  input  logic [1:0]        st_size,
  input  logic [ADDR_W-1:0] st_base,
  input  logic [OFFS_W-1:0] st_offs,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_out_valid,
  input  logic              st_out_ready,
  output logic [ADDR_W-1:0] st_addr,
  output logic [NL-1:0]     st_be,
  output logic [DATA_W-1:0] st_wword,
  output logic              st_misal,
  input  logic              ld_in_valid,
  output logic              ld_in_ready,
  input  logic [1:0]        ld_size,
  input  logic              ld_signed,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [OFFS_W-1:0] ld_offs,
  input  logic [DATA_W-1:0] ld_rword,
  output logic              ld_out_valid,
  input  logic              ld_out_ready,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_result,
  output logic              ld_misal
);
  // ---------------- store channel ----------------
  logic [ADDR_W-1:0] st_wa_c;
  logic [LB-1:0]     st_off_c;
  logic              st_mis_c;
  logic [NL-1:0]     fmt_be;
  logic [DATA_W-1:0] fmt_word;

  lsa_ea_gen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LB(LB)) u_st_ea (
    .base(st_base), .offs(st_offs), .size(st_size),
    .word_addr(st_wa_c), .lane_off(st_off_c), .misal(st_mis_c)
  );

  lsa_store_fmt #(.DATA_W(DATA_W)) u_st_fmt (
    .size(st_size), .big_end(big_end_i), .lane_off(st_off_c),
    .wdata(st_data), .be(fmt_be), .wword(fmt_word)
  );

  lsa_pipe_reg #(.W(ST_W)) u_st_reg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(st_in_valid), .in_ready(st_in_ready),
    .in_data({st_wa_c, fmt_be, fmt_word, st_mis_c}),
    .out_valid(st_out_valid), .out_ready(st_out_ready),
    .out_data({st_addr, st_be, st_wword, st_misal})
  );

  // ---------------- load channel (R10: no shared state) ----------------
  logic [ADDR_W-1:0] ld_wa_c;
  logic [LB-1:0]     ld_off_c;
  logic              ld_mis_c;
  logic [DATA_W-1:0] ld_res_c;

  lsa_ea_gen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LB(LB)) u_ld_ea (
    .base(ld_base), .offs(ld_offs), .size(ld_size),
    .word_addr(ld_wa_c), .lane_off(ld_off_c), .misal(ld_mis_c)
  );

  lsa_load_ext #(.DATA_W(DATA_W)) u_ld_ext (
    .size(ld_size), .sgn(ld_signed), .big_end(big_end_i),
    .lane_off(ld_off_c), .rword(ld_rword), .result(ld_res_c)
  );

  lsa_pipe_reg #(.W(LD_W)) u_ld_reg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ld_in_valid), .in_ready(ld_in_ready),
    .in_data({ld_wa_c, ld_res_c, ld_mis_c}),
    .out_valid(ld_out_valid), .out_ready(ld_out_ready),
    .out_data({ld_addr, ld_result, ld_misal})
  );

  // ---------------- checks on formatter / extractor ----------------
  a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (st_in_valid && (st_size == ACC_BYTE)) |-> ($countones(fmt_be) == 1));

  a_r4_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_in_valid && (st_size == ACC_WORD)) |-> (&fmt_be));

  a_r8_byte_never_misal: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_in_valid && (st_size == ACC_BYTE)) || (ld_in_valid && (ld_size == ACC_BYTE)))
      |-> (!st_mis_c || st_size != ACC_BYTE) && (!ld_mis_c || ld_size != ACC_BYTE));

  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_in_valid && (ld_size == ACC_BYTE) && !ld_signed) |-> (ld_res_c[DATA_W-1:8] == '0));
endmodule

// File: tb/lsalign_unit_test.sv
module lsalign_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_end_i = 1'b0;
  logic        st_in_valid = 1'b0, st_out_ready = 1'b1;
  logic [1:0]  st_size = '0;
  logic [31:0] st_base = '0, st_data = '0;
  logic [15:0] st_offs = '0;
  logic        ld_in_valid = 1'b0, ld_signed = 1'b0, ld_out_ready = 1'b1;
  logic [1:0]  ld_size = '0;
  logic [31:0] ld_base = '0, ld_rword = '0;
  logic [15:0] ld_offs = '0;
  logic        st_in_ready, st_out_valid, st_misal;
  logic [31:0] st_addr, st_wword;
  logic [3:0]  st_be;
  logic        ld_in_ready, ld_out_valid, ld_misal;
  logic [31:0] ld_addr, ld_result;

  lsalign_unit uut (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] addr; logic [3:0] be; logic [31:0] ww; logic mis; string tag;
  } st_exp_t;
  typedef struct {
    logic [31:0] addr; logic [31:0] res; logic mis; string tag;
  } ld_exp_t;

  st_exp_t sq[$];
  ld_exp_t lq[$];
  int checks = 0, fails = 0, cyc = 0;
  bit st_rand = 0, ld_rand = 0, ld_hold = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // ---- reference model from the requirements ----
  function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction
  function automatic logic mis_of(input logic [1:0] sz, input logic [31:0] ea);
    if (sz == 2'd0) return 1'b0;
    if (sz == 2'd1) return ea[0];
    return ea[1:0] != 2'b00;
  endfunction
  function automatic int blane(input logic be, input logic [1:0] a);
    return be ? 3 - int'(a) : int'(a);
  endfunction
  function automatic int hpair(input logic be, input logic a1);
    return be ? 1 - int'(a1) : int'(a1);
  endfunction

  task automatic put_store(input logic [1:0] sz, input logic [31:0] b,
                           input logic [15:0] o, input logic [31:0] d);
    st_exp_t e;
    logic [31:0] ea;
    ea = ea_of(b, o);
    e.addr = {ea[31:2], 2'b00};
    e.mis  = mis_of(sz, ea);
    if (sz == 2'd0) begin
      e.be = 4'b0001 << blane(big_end_i, ea[1:0]);
      e.ww = {4{d[7:0]}};
      e.tag = "R2";
    end else if (sz == 2'd1) begin
      e.be = (hpair(big_end_i, ea[1]) == 1) ? 4'b1100 : 4'b0011;
      e.ww = {2{d[15:0]}};
      e.tag = "R3";
    end else begin
      e.be = 4'b1111;
      e.ww = d;
      e.tag = "R4";
    end
    if (e.mis) e.tag = "R8";
    @(negedge clk);
    st_size = sz; st_base = b; st_offs = o; st_data = d; st_in_valid = 1'b1;
    #1;
    while (!st_in_ready) begin @(negedge clk); #1; end
    sq.push_back(e);
    @(posedge clk); #1;
    st_in_valid = 1'b0;
  endtask

  task automatic put_load(input logic [1:0] sz, input logic sg, input logic [31:0] b,
                          input logic [15:0] o, input logic [31:0] w,
                          input bit use_lit, input logic [31:0] lit);
    ld_exp_t e;
    logic [31:0] ea;
    logic [7:0]  by;
    logic [15:0] hw;
    ea = ea_of(b, o);
    e.addr = {ea[31:2], 2'b00};
    e.mis  = mis_of(sz, ea);
    by = w[8*blane(big_end_i, ea[1:0]) +: 8];
    hw = w[16*hpair(big_end_i, ea[1]) +: 16];
    if (sz == 2'd0) begin
      e.res = {{24{sg & by[7]}}, by}; e.tag = "R5";
    end else if (sz == 2'd1) begin
      e.res = {{16{sg & hw[15]}}, hw}; e.tag = "R6";
    end else begin
      e.res = w; e.tag = "R7";
    end
    if (use_lit) e.res = lit;
    if (e.mis) e.tag = "R8";
    @(negedge clk);
    ld_size = sz; ld_signed = sg; ld_base = b; ld_offs = o; ld_rword = w;
    ld_in_valid = 1'b1;
    #1;
    while (!ld_in_ready) begin @(negedge clk); #1; end
    lq.push_back(e);
    @(posedge clk); #1;
    ld_in_valid = 1'b0;
  endtask

  // ---- monitor / scoreboard ----
  always @(negedge clk) begin
    if (rst_n) begin
      st_out_ready = st_rand ? ($urandom % 4 != 0) : 1'b1;
      ld_out_ready = ld_hold ? 1'b0 : (ld_rand ? ($urandom % 3 != 0) : 1'b1);
      if (st_out_valid && st_out_ready) begin
        if (sq.size() == 0) chk(0, "R9", "unexpected store beat", st_addr, 32'h0);
        else begin
          st_exp_t e;
          e = sq.pop_front();
          chk(st_addr == e.addr, "R1", "st_addr", st_addr, e.addr);
          chk(st_misal == e.mis, e.tag, "st_misal", {31'b0, st_misal}, {31'b0, e.mis});
          if (!e.mis) begin
            chk(st_be == e.be, e.tag, "st_be", {28'b0, st_be}, {28'b0, e.be});
            chk(st_wword == e.ww, e.tag, "st_wword", st_wword, e.ww);
          end
        end
      end
      if (ld_out_valid && ld_out_ready) begin
        if (lq.size() == 0) chk(0, "R9", "unexpected load beat", ld_addr, 32'h0);
        else begin
          ld_exp_t e;
          e = lq.pop_front();
          chk(ld_addr == e.addr, "R1", "ld_addr", ld_addr, e.addr);
          chk(ld_misal == e.mis, e.tag, "ld_misal", {31'b0, ld_misal}, {31'b0, e.mis});
          if (!e.mis) chk(ld_result == e.res, e.tag, "ld_result", ld_result, e.res);
        end
      end
    end
  end

  // ---- watchdog ----
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", cyc, 100000);
      report();
      $finish;
    end
  end

  task automatic drain();
    while (sq.size() != 0 || lq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic directed(input logic be);
    big_end_i = be;
    for (int a = 0; a < 4; a++) put_store(2'd0, 32'h0000_2000, 16'(a), 32'h0000_00A5 + a);  // R2
    put_store(2'd1, 32'h0000_2000, 16'd0, 32'h0000_BEEF);                                    // R3
    put_store(2'd1, 32'h0000_2000, 16'd2, 32'h0000_1234);                                    // R3
    put_store(2'd2, 32'h0000_1000, 16'd0, 32'hCAFE_F00D);                                    // R4
    put_store(2'd2, 32'h0000_1002, 16'd0, 32'hCAFE_F00D);                                    // R4/R8
    put_store(2'd1, 32'h0000_1001, 16'd0, 32'h0000_7777);                                    // R8
    put_store(2'd0, 32'h0000_0100, 16'hFFFF, 32'h0000_003C);                                 // R1 negative
    put_store(2'd2, 32'h0000_0000, 16'd0, 32'h2345_6789);
    put_load(2'd0, 1'b1, 32'h0, 16'd1, 32'h2345_6789, 1,
             be ? 32'h0000_0045 : 32'h0000_0067);                                            // R5 example
    for (int a = 0; a < 4; a++) begin
      put_load(2'd0, 1'b1, 32'h0000_3000, 16'(a), 32'h80F1_7F02, 0, 32'h0);                  // R5
      put_load(2'd0, 1'b0, 32'h0000_3000, 16'(a), 32'h80F1_7F02, 0, 32'h0);                  // R5
    end
    put_load(2'd1, 1'b1, 32'h0000_3000, 16'd0, 32'h8001_7FFE, 0, 32'h0);                     // R6
    put_load(2'd1, 1'b0, 32'h0000_3000, 16'd2, 32'h8001_7FFE, 0, 32'h0);                     // R6
    put_load(2'd1, 1'b1, 32'h0000_3000, 16'd2, 32'h7FFE_8001, 0, 32'h0);                     // R6
    put_load(2'd2, 1'b1, 32'h0000_3003, 16'd0, 32'h8765_4321, 0, 32'h0);                     // R7/R8
    put_load(2'd2, 1'b1, 32'h0000_3004, 16'hFFFC, 32'hF000_0001, 0, 32'h0);                  // R7, R1
    put_load(2'd1, 1'b0, 32'h0000_3001, 16'd0, 32'h1111_2222, 0, 32'h0);                     // R8
    put_load(2'd0, 1'b0, 32'h0000_3003, 16'd0, 32'h1111_2222, 0, 32'h0);                     // R8 byte
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(st_out_valid == 1'b0, "R9", "reset st_out_valid", {31'b0, st_out_valid}, 32'h0);
    chk(ld_out_valid == 1'b0, "R9", "reset ld_out_valid", {31'b0, ld_out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_in_ready == 1'b1, "R9", "idle st_in_ready", {31'b0, st_in_ready}, 32'h1);

    directed(1'b0);
    directed(1'b1);

    // R10: both channels accept in the same cycle
    big_end_i = 1'b0;
    fork
      put_store(2'd1, 32'h0000_4000, 16'd2, 32'h0000_ABCD);
      put_load(2'd0, 1'b1, 32'h0000_4000, 16'd3, 32'h9A00_0000, 0, 32'h0);
    join
    drain();

    // R9/R10: stall the load output while stores keep flowing
    ld_hold = 1;
    put_load(2'd1, 1'b1, 32'h0000_5000, 16'd2, 32'hC3A5_0000, 0, 32'h0);
    @(negedge clk); #2;
    chk(ld_out_valid == 1'b1, "R9", "stalled ld_out_valid", {31'b0, ld_out_valid}, 32'h1);
    chk(ld_in_ready == 1'b0, "R9", "stalled ld_in_ready", {31'b0, ld_in_ready}, 32'h0);
    for (int i = 0; i < 3; i++) put_store(2'd0, 32'h0000_6000, 16'(i), 32'h11 * (i + 1));
    repeat (3) @(negedge clk);
    chk(sq.size() == 0, "R10", "stores drained under load stall", sq.size(), 32'h0);
    chk(lq.size() == 1, "R9", "load still held", lq.size(), 32'h1);
    ld_hold = 0;
    drain();

    // random traffic, both modes, random back-pressure
    st_rand = 1; ld_rand = 1;
    for (int m = 0; m < 2; m++) begin
      big_end_i = m[0];
      fork
        for (int i = 0; i < 150; i++)
          put_store(2'($urandom % 3), $urandom, 16'($urandom), $urandom);
        for (int i = 0; i < 150; i++)
          put_load(2'($urandom % 3), 1'($urandom), $urandom, 16'($urandom), $urandom, 0, 32'h0);
      join
      drain();
    end
    st_rand = 0; ld_rand = 0;

    done = 1;
    report();
    $finish;
  end
endmodule